// File: doc/BRIEF.md
# Banked Cascaded Interrupt Aggregator

This block collects 96 level-sensitive peripheral interrupt lines into three 32-bit status banks. Line k lands in bank k/32 at bit k mod 32. Each bank is masked by two independent sets of enable registers. Each set drives its own CPU interrupt line. A line is raised when any bank holds a bit that is both pending and enabled in that set.

Two sub-controllers sit one level below the banks:
- A software-interrupt sub-controller holds a 32-bit request register, which only bus writes can set or clear, and a 32-bit enable register. The OR of its masked bits takes the place of one bit of bank 0.
- A 32-line GPIO interrupt input is masked by its own 32-bit enable register. The OR of the masked result takes the place of one bit of bank 1.

Both cascade positions are parameters. A small register bus gives write access to all enable registers and to the software request register. It gives read access to every register, and reads are combinational.

Top module: `irq_bank_aggregator`

## Requirements
- R1: With the default of three banks, status word addresses are 0, 1 and 2. Status bank n bit i reads the live level of periph_irq[32n+i], except at the two cascade positions.
- R2: After reset every enable register and the software request register read zero, and cpu_irq_a and cpu_irq_b are low.
- R3: cpu_irq_a equals, one clock edge later, the OR over all three banks of (status AND set-A enable). Set-A enables are at addresses 3, 4 and 5 for banks 0, 1 and 2.
- R4: cpu_irq_b is computed the same way from the same status and its own set-B enables, at addresses 6, 7 and 8. Set-A and set-B enables have no effect on each other's output.
- R5: Bank 0 bit SW_CASC_BIT (default 7) reads the OR of (software request AND software enable). periph_irq at that position has no effect.
- R6: Bank 1 bit GPIO_CASC_BIT (default 9) reads the OR of (gpio_irq AND GPIO enable). periph_irq at that position has no effect. The GPIO enable is at address 11, and the raw gpio_irq value reads at address 12.
- R7: The software request register at address 9 changes only on a bus write to address 9. The software enable register is at address 10.
- R8: Writes to status addresses 0 to 2 and to address 12 change no register and no output.
- R9: Addresses 13 to 15 read zero.
- R10: Every enable register reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_irq | input | 96 | Peripheral interrupt levels, line k to bank k/32 bit k mod 32 |
| gpio_irq | input | 32 | GPIO interrupt levels |
| bus_we | input | 1 | Register write strobe, captured on the rising clock edge |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| cpu_irq_a | output | 1 | Registered interrupt line for enable set A |
| cpu_irq_b | output | 1 | Registered interrupt line for enable set B |

## Verification
Read data is combinational, so a status or enable read is due in the same cycle as the address and any input level it reflects. The bench samples it a short delay after driving the address on the falling edge.

A register write takes effect on the rising edge under the strobe. Each interrupt output moves on the rising edge after that, so an enable change shows on the line one cycle after the write edge. An input line change shows on the output at the first rising edge after the line moves.

The latency tests check each output at the falling edge before its due edge and again at the falling edge after it. The table vectors wait two falling edges after their last write before sampling.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_STAT,
        RK_EN_A,
        RK_EN_B,
        RK_SW_REQ,
        RK_SW_EN,
        RK_GPIO_EN,
        RK_GPIO_ST
    } reg_kind_e;

    // Word map: status banks, set-A enables, set-B enables, then the
    // sub-controller registers, all packed from address zero.
    function automatic reg_kind_e decode_kind(input int unsigned addr,
                                              input int unsigned nb);
        if (addr < nb)              return RK_STAT;
        else if (addr < 2 * nb)     return RK_EN_A;
        else if (addr < 3 * nb)     return RK_EN_B;
        else if (addr == 3 * nb)    return RK_SW_REQ;
        else if (addr == 3 * nb + 1) return RK_SW_EN;
        else if (addr == 3 * nb + 2) return RK_GPIO_EN;
        else if (addr == 3 * nb + 3) return RK_GPIO_ST;
        else                        return RK_NONE;
    endfunction

    function automatic int unsigned decode_bank(input int unsigned addr,
                                                input int unsigned nb);
        return addr % nb;
    endfunction

endpackage

// File: rtl/irq_sub_ctrl.sv
// Second-level interrupt source: a bus-written request register ORed with
// external request levels, masked by its own enable register, reduced to
// one cascade bit.
module irq_sub_ctrl #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ext_req,
    input  logic [W-1:0] wdata,
    input  logic         req_we,
    input  logic         en_we,
    output logic [W-1:0] raw_o,
    output logic [W-1:0] en_o,
    output logic         casc_o
);

    typedef struct packed {
        logic [W-1:0] req;
        logic [W-1:0] en;
    } sub_state_t;

    sub_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (req_we) st_d.req = wdata;
        if (en_we)  st_d.en  = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw_o  = st_q.req | ext_req;
    assign en_o   = st_q.en;
    assign casc_o = |(raw_o & st_q.en);

endmodule

// File: rtl/irq_bank_status.sv
// Builds the status banks from the peripheral levels, substituting the two
// cascade bits at their parameterised positions.
module irq_bank_status #(
    parameter int unsigned NB       = 3,
    parameter int unsigned BW       = 32,
    parameter int unsigned SW_BIT   = 7,
    parameter int unsigned GPIO_BIT = 9
) (
    input  logic [NB*BW-1:0] periph_i,
    input  logic             sw_casc_i,
    input  logic             gpio_casc_i,
    output logic [NB*BW-1:0] status_o
);

    localparam int unsigned SW_POS   = SW_BIT;
    localparam int unsigned GPIO_POS = BW + GPIO_BIT;

    always_comb begin
        status_o           = periph_i;
        status_o[SW_POS]   = sw_casc_i;
        status_o[GPIO_POS] = gpio_casc_i;
    end

endmodule

// File: rtl/irq_bank_reduce.sv
// Per-bank masked pending for one enable set.
module irq_bank_reduce #(
    parameter int unsigned NB = 3,
    parameter int unsigned BW = 32
) (
    input  logic [NB*BW-1:0] status_i,
    input  logic [NB*BW-1:0] en_i,
    output logic [NB-1:0]    pend_o
);

    for (genvar b = 0; b < NB; b++) begin : g_bank
        assign pend_o[b] = |(status_i[b*BW +: BW] & en_i[b*BW +: BW]);
    end

endmodule

// File: rtl/irq_bank_aggregator.sv
module irq_bank_aggregator
    import irq_agg_pkg::*;
#(
    parameter int unsigned NUM_BANKS     = 3,
    parameter int unsigned BANK_W        = 32,
    parameter int unsigned SW_W          = 32,
    parameter int unsigned GPIO_W        = 32,
    parameter int unsigned SW_CASC_BIT   = 7,
    parameter int unsigned GPIO_CASC_BIT = 9,
    parameter int unsigned ADDR_W        = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_BANKS*BANK_W-1:0] periph_irq,
    input  logic [GPIO_W-1:0]           gpio_irq,
    input  logic                        bus_we,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [BANK_W-1:0]           bus_wdata,
    output logic [BANK_W-1:0]           bus_rdata,
    output logic                        cpu_irq_a,
    output logic                        cpu_irq_b
);

    localparam int unsigned TOT_W = NUM_BANKS * BANK_W;

    typedef struct packed {
        logic [TOT_W-1:0] en_a;
        logic [TOT_W-1:0] en_b;
        logic             irq_a;
        logic             irq_b;
    } agg_state_t;

    agg_state_t st_d, st_q;

    reg_kind_e   kind;
    int unsigned bidx;

    logic [TOT_W-1:0]     status_w;
    logic [TOT_W-1:0]     en_a_w;
    logic [TOT_W-1:0]     en_b_w;
    logic [NUM_BANKS-1:0] pend_a;
    logic [NUM_BANKS-1:0] pend_b;
    logic [SW_W-1:0]      sw_req_w;
    logic [SW_W-1:0]      sw_en_w;
    logic [GPIO_W-1:0]    gpio_raw_w;
    logic [GPIO_W-1:0]    gpio_en_w;
    logic                 sw_casc;
    logic                 gpio_casc;
    logic                 sw_req_we;
    logic                 sw_en_we;
    logic                 gpio_en_we;

    assign kind = decode_kind(int'(bus_addr), NUM_BANKS);
    assign bidx = decode_bank(int'(bus_addr), NUM_BANKS);

    assign sw_req_we  = bus_we && (kind == RK_SW_REQ);
    assign sw_en_we   = bus_we && (kind == RK_SW_EN);
    assign gpio_en_we = bus_we && (kind == RK_GPIO_EN);

    irq_sub_ctrl #(.W(SW_W)) u_sw (
        .clk    (clk),
        .rst_n  (rst_n),
        .ext_req('0),
        .wdata  (bus_wdata[SW_W-1:0]),
        .req_we (sw_req_we),
        .en_we  (sw_en_we),
        .raw_o  (sw_req_w),
        .en_o   (sw_en_w),
        .casc_o (sw_casc)
    );

    irq_sub_ctrl #(.W(GPIO_W)) u_gpio (
        .clk    (clk),
        .rst_n  (rst_n),
        .ext_req(gpio_irq),
        .wdata  (bus_wdata[GPIO_W-1:0]),
        .req_we (1'b0),
        .en_we  (gpio_en_we),
        .raw_o  (gpio_raw_w),
        .en_o   (gpio_en_w),
        .casc_o (gpio_casc)
    );

    irq_bank_status #(
        .NB      (NUM_BANKS),
        .BW      (BANK_W),
        .SW_BIT  (SW_CASC_BIT),
        .GPIO_BIT(GPIO_CASC_BIT)
    ) u_status (
        .periph_i   (periph_irq),
        .sw_casc_i  (sw_casc),
        .gpio_casc_i(gpio_casc),
        .status_o   (status_w)
    );

    assign en_a_w = st_q.en_a;
    assign en_b_w = st_q.en_b;

    irq_bank_reduce #(.NB(NUM_BANKS), .BW(BANK_W)) u_reduce_a (
        .status_i(status_w),
        .en_i    (en_a_w),
        .pend_o  (pend_a)
    );

    irq_bank_reduce #(.NB(NUM_BANKS), .BW(BANK_W)) u_reduce_b (
        .status_i(status_w),
        .en_i    (en_b_w),
        .pend_o  (pend_b)
    );

    // Next state: enable writes and the registered output lines.
    always_comb begin
        st_d = st_q;
        if (bus_we) begin
            case (kind)
                RK_EN_A: st_d.en_a[bidx*BANK_W +: BANK_W] = bus_wdata;
                RK_EN_B: st_d.en_b[bidx*BANK_W +: BANK_W] = bus_wdata;
                default: ;
            endcase
        end
        st_d.irq_a = |pend_a;
        st_d.irq_b = |pend_b;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (kind)
            RK_STAT:    bus_rdata = status_w[bidx*BANK_W +: BANK_W];
            RK_EN_A:    bus_rdata = st_q.en_a[bidx*BANK_W +: BANK_W];
            RK_EN_B:    bus_rdata = st_q.en_b[bidx*BANK_W +: BANK_W];
            RK_SW_REQ:  bus_rdata = BANK_W'(sw_req_w);
            RK_SW_EN:   bus_rdata = BANK_W'(sw_en_w);
            RK_GPIO_EN: bus_rdata = BANK_W'(gpio_en_w);
            RK_GPIO_ST: bus_rdata = BANK_W'(gpio_raw_w);
            default:    bus_rdata = '0;
        endcase
    end

    assign cpu_irq_a = st_q.irq_a;
    assign cpu_irq_b = st_q.irq_b;

endmodule

// File: rtl/irq_bank_aggregator_chk.sv
module irq_bank_aggregator_chk #(
    parameter int unsigned NB       = 3,
    parameter int unsigned BW       = 32,
    parameter int unsigned SW_W     = 32,
    parameter int unsigned GPIO_W   = 32,
    parameter int unsigned SW_BIT   = 7,
    parameter int unsigned GPIO_BIT = 9,
    parameter int unsigned ADDR_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NB*BW-1:0]  status,
    input logic [NB*BW-1:0]  en_a,
    input logic [NB*BW-1:0]  en_b,
    input logic [SW_W-1:0]   sw_req,
    input logic [SW_W-1:0]   sw_en,
    input logic [GPIO_W-1:0] gpio_irq,
    input logic [GPIO_W-1:0] gpio_en,
    input logic              irq_a,
    input logic              irq_b
);

    localparam int unsigned A_SWR = 3 * NB;

    logic any_a, any_b;
    assign any_a = |(status & en_a);
    assign any_b = |(status & en_b);

    p_irq_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (irq_a == $past(any_a)));

    p_irq_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (irq_b == $past(any_b)));

    p_sw_casc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |-> (status[SW_BIT] == |(sw_req & sw_en)));

    p_gpio_casc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |-> (status[BW + GPIO_BIT] == |(gpio_irq & gpio_en)));

    p_sw_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !(bus_we && bus_addr == ADDR_W'(A_SWR))) |=> $stable(sw_req));

endmodule

bind irq_bank_aggregator irq_bank_aggregator_chk #(
    .NB      (NUM_BANKS),
    .BW      (BANK_W),
    .SW_W    (SW_W),
    .GPIO_W  (GPIO_W),
    .SW_BIT  (SW_CASC_BIT),
    .GPIO_BIT(GPIO_CASC_BIT),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_we  (bus_we),
    .bus_addr(bus_addr),
    .status  (status_w),
    .en_a    (en_a_w),
    .en_b    (en_b_w),
    .sw_req  (sw_req_w),
    .sw_en   (sw_en_w),
    .gpio_irq(gpio_irq),
    .gpio_en (gpio_en_w),
    .irq_a   (cpu_irq_a),
    .irq_b   (cpu_irq_b)
);

// File: tb/irq_bank_aggregator_bench.sv
module irq_bank_aggregator_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [95:0] periph;
    logic [31:0] gpio;
    logic        we;
    logic [3:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        irq_a, irq_b;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    irq_bank_aggregator u_irq_bank_aggregator (
        .clk       (clk),
        .rst_n     (rst_n),
        .periph_irq(periph),
        .gpio_irq  (gpio),
        .bus_we    (we),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .cpu_irq_a (irq_a),
        .cpu_irq_b (irq_b)
    );

    typedef struct packed {
        logic [95:0] periph;
        logic [31:0] gpio;
        logic [95:0] ena;
        logic [95:0] enb;
        logic [31:0] swr;
        logic [31:0] swe;
        logic [31:0] gpe;
        logic        exp_a;
        logic        exp_b;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        // R3: bank 0 line 5 enabled in set A only
        '{(96'd1 << 5), 32'd0, (96'd1 << 5), 96'd0, 32'd0, 32'd0, 32'd0, 1'b1, 1'b0},
        // R4: line 40 enabled in set B, set A enables a neighbour bit
        '{(96'd1 << 40), 32'd0, (96'd1 << 41), (96'd1 << 40), 32'd0, 32'd0, 32'd0, 1'b0, 1'b1},
        // R3/R4: top line of bank 2 in both sets
        '{(96'd1 << 95), 32'd0, (96'd1 << 95), (96'd1 << 95), 32'd0, 32'd0, 32'd0, 1'b1, 1'b1},
        // R5: software request 3 enabled, cascade bit 7 enabled in set A
        '{96'd0, 32'd0, (96'd1 << 7), 96'd0, 32'h8, 32'h8, 32'd0, 1'b1, 1'b0},
        // R5: request 3 but only enable 4: cascade stays low
        '{96'd0, 32'd0, (96'd1 << 7), 96'd0, 32'h8, 32'h10, 32'd0, 1'b0, 1'b0},
        // R6: GPIO 20 enabled, bank 1 bit 9 enabled in set B
        '{96'd0, (32'd1 << 20), 96'd0, (96'd1 << 41), 32'd0, 32'd0, (32'd1 << 20), 1'b0, 1'b1},
        // R5: peripheral line at the software cascade position is ignored
        '{(96'd1 << 7), 32'd0, (96'd1 << 7), 96'd0, 32'd0, 32'd0, 32'd0, 1'b0, 1'b0},
        // R6: peripheral line at the GPIO cascade position is ignored
        '{(96'd1 << 41), 32'd0, (96'd1 << 41), (96'd1 << 41), 32'd0, 32'd0, 32'd0, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic clear_all();
        for (int a = 3; a <= 11; a++) wr(4'(a), 32'd0);
        periph = '0;
        gpio   = '0;
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #200000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired before completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0; periph = '0; gpio = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: reset state
        check("R2 irq_a", {31'd0, irq_a}, 32'd0);
        check("R2 irq_b", {31'd0, irq_b}, 32'd0);
        for (int a = 3; a <= 11; a++) begin
            rd(4'(a), d);
            check("R2 reg zero", d, 32'd0);
        end

        // Table walk (R3, R4, R5, R6)
        for (int i = 0; i < NV; i++) begin
            clear_all();
            for (int b = 0; b < 3; b++) begin
                wr(4'(3 + b), VECS[i].ena[b*32 +: 32]);
                wr(4'(6 + b), VECS[i].enb[b*32 +: 32]);
            end
            wr(4'd9,  VECS[i].swr);
            wr(4'd10, VECS[i].swe);
            wr(4'd11, VECS[i].gpe);
            periph = VECS[i].periph;
            gpio   = VECS[i].gpio;
            repeat (2) @(negedge clk);
            check("R3 table irq_a", {31'd0, irq_a}, {31'd0, VECS[i].exp_a});
            check("R4 table irq_b", {31'd0, irq_b}, {31'd0, VECS[i].exp_b});
        end

        // R1: bank mapping of live levels
        clear_all();
        periph = (96'd1 << 3) | (96'd1 << 33) | (96'd1 << 70);
        @(negedge clk);
        rd(4'd0, d); check("R1 bank0", d, 32'h0000_0008);
        rd(4'd1, d); check("R1 bank1", d, 32'h0000_0002);
        rd(4'd2, d); check("R1 bank2", d, 32'h0000_0040);

        // R5: cascade bit from software sub-controller, peripheral line 7 ignored
        periph[7] = 1'b1;
        rd(4'd0, d); check("R5 line7 ignored", d, 32'h0000_0008);
        wr(4'd9, 32'h1);
        wr(4'd10, 32'h1);
        rd(4'd0, d); check("R5 cascade set", d, 32'h0000_0088);

        // R6: GPIO cascade and raw read
        gpio = 32'h10;
        periph[41] = 1'b1;
        wr(4'd11, 32'h10);
        rd(4'd1, d);  check("R6 cascade set", d, 32'h0000_0202);
        rd(4'd12, d); check("R6 raw gpio", d, 32'h0000_0010);
        gpio = 32'h0;
        rd(4'd1, d);  check("R6 cascade follows", d, 32'h0000_0002);

        // R8: writes to status and GPIO raw addresses have no effect
        wr(4'd0, 32'hFFFF_FFFF);
        wr(4'd2, 32'hFFFF_FFFF);
        wr(4'd12, 32'hFFFF_FFFF);
        rd(4'd0, d);  check("R8 bank0 unchanged", d, 32'h0000_0088);
        rd(4'd2, d);  check("R8 bank2 unchanged", d, 32'h0000_0040);
        rd(4'd12, d); check("R8 gpio raw unchanged", d, 32'h0000_0000);
        check("R8 irq_a quiet", {31'd0, irq_a}, 32'd0);

        // R7: software request changes only on its own write
        wr(4'd9, 32'h11);
        periph = ~96'd0;
        gpio   = ~32'd0;
        wr(4'd10, 32'h0);
        repeat (3) @(negedge clk);
        rd(4'd9, d); check("R7 request held", d, 32'h0000_0011);
        wr(4'd9, 32'h0);
        rd(4'd9, d); check("R7 request cleared", d, 32'h0000_0000);

        // R9: unmapped addresses
        rd(4'd13, d); check("R9 addr13", d, 32'd0);
        rd(4'd15, d); check("R9 addr15", d, 32'd0);

        // R10: enable readback
        clear_all();
        wr(4'd4, 32'hA5A5_5A5A);
        wr(4'd8, 32'h1234_5678);
        rd(4'd4, d); check("R10 set A bank1", d, 32'hA5A5_5A5A);
        rd(4'd8, d); check("R10 set B bank2", d, 32'h1234_5678);
        rd(4'd5, d); check("R10 set A bank2", d, 32'h0);
        rd(4'd7, d); check("R10 set B bank1", d, 32'h0);

        // R3 latency: input change and enable change
        clear_all();
        wr(4'd3, 32'h8);
        @(negedge clk);
        periph[3] = 1'b1;
        #1 check("R3 before edge", {31'd0, irq_a}, 32'd0);
        @(negedge clk);
        check("R3 one edge later", {31'd0, irq_a}, 32'd1);
        check("R4 set B untouched", {31'd0, irq_b}, 32'd0);
        wr(4'd6, 32'h8);
        check("R4 before edge", {31'd0, irq_b}, 32'd0);
        @(negedge clk);
        check("R4 after edge", {31'd0, irq_b}, 32'd1);
        wr(4'd3, 32'h0);
        check("R3 mask before edge", {31'd0, irq_a}, 32'd1);
        @(negedge clk);
        check("R3 mask after edge", {31'd0, irq_a}, 32'd0);
        check("R4 independent", {31'd0, irq_b}, 32'd1);

        // R2: reset in mid-run clears enables and outputs
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 irq_b after reset", {31'd0, irq_b}, 32'd0);
        rd(4'd6, d); check("R2 set B cleared", d, 32'd0);

        finish_run();
    end

endmodule